// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the eight status flags of a serial communication interface. It sits between the transmit/receive datapath and the CPU bus. The datapath sends it one-cycle event pulses: a buffered transmit byte was moved into the shift register, a data frame finished, a preamble or break frame finished, a received byte was moved into the data register, an idle line was seen, and four error strobes. The bus side sends read strobes for the status register and the data register, and a write strobe for the data register.

Software clears flags with a two-step sequence. A status read takes a snapshot of the flags. The next data-register access then clears only those snapshot flags that belong to the direction of that access. A write clears the transmit flags. A read clears the receive, idle and error flags. The block drives a read-only status byte, a permission signal that tells the datapath when it may load the next transmit byte, and one registered interrupt line.

The block has no data streams, so every pin is a plain control or status level or pulse. There is no valid/ready back-pressure. Pulses are sampled on every rising clock edge.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status byte is 0xC0 (transmit-empty and transmit-complete set, all others clear), `tx_load_ok` is 0 and `irq` is 0.
- R2: The status bit layout is: bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-ready, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity. Each bit is set one clock after its event pulse. The four error strobes may arrive together.
- R3: `ev_tx_moved` sets bit 7. `tx_load_ok` is 1 exactly while bit 7 is 0.
- R4: `ev_frame_done` sets bit 6. `ev_special_done` (preamble or break finished) never sets bit 6.
- R5: A status read followed by a data-register write clears whichever of bits 7 and 6 were set when the status was read. A data write with no armed status read leaves every flag unchanged.
- R6: A status read followed by a data-register read clears whichever of bits 5 to 0 were set when the status was read. A flag set after that status read survives the clear.
- R7: An armed status read is used up by the first data access of either direction. A data read never clears bits 7 and 6, and a data write never clears bits 5 to 0. A second access needs a new status read.
- R8: When a set event and a sequence clear hit the same flag in the same cycle, the flag ends up 1.
- R9: After the idle flag has been set, further idle events are ignored until a receive event (`ev_rx_moved`) has occurred.
- R10: `irq` is registered. One clock after the flags change, it equals the OR of status bits 7..4, each ANDed with `irq_en[3..0]` in the same order. The error bits never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_moved | input | 1 | Transmit buffer byte moved to shift register |
| ev_frame_done | input | 1 | Data frame transmission finished |
| ev_special_done | input | 1 | Preamble or break frame finished |
| ev_rx_moved | input | 1 | Received byte moved to data register |
| ev_idle_seen | input | 1 | Idle line detected |
| err_overrun | input | 1 | Overrun error strobe |
| err_noise | input | 1 | Noise error strobe |
| err_framing | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| bus_stat_rd | input | 1 | Status register read strobe |
| bus_data_rd | input | 1 | Data register read strobe |
| bus_data_wr | input | 1 | Data register write strobe |
| irq_en | input | 4 | Interrupt enables for status bits 7..4 |
| status | output | 8 | Read-only status byte |
| tx_load_ok | output | 1 | Datapath may move the next transmit byte |
| irq | output | 1 | Combined registered interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- a set event always leaves its flag at 1 on the next cycle;
- the clear latch is always dropped after a data access;
- transmit flags never clear unless a sequence is armed;
- a preamble or break never raises transmit-complete;
- a locked idle flag stays clear;
- the interrupt stays low when all enables are zero.

Other behaviour can only be shown by the bench's directed scenarios:
- which flags the snapshot clears, and that a flag set after the snapshot survives;
- that clearing is split by direction;
- that the latch is used up by a single access;
- the exact status byte values and the one-cycle delay of the interrupt.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned IRQ_SRCS = 4;
  localparam int unsigned B_TXE  = 7;
  localparam int unsigned B_TC   = 6;
  localparam int unsigned B_RXR  = 5;
  localparam int unsigned B_IDLE = 4;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_NSE  = 2;
  localparam int unsigned B_FRM  = 1;
  localparam int unsigned B_PAR  = 0;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = 8'hC0;
  // flags cleared by a data write (transmit side); the rest clear on a data read
  localparam logic [FLAG_W-1:0] WR_CLEAR_SET = 8'hC0;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // set has priority over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/uart_flag_clear_seq.sv
module uart_flag_clear_seq
  import uart_flag_pkg::*;
#(
  parameter int unsigned W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_rd_i,
  input  logic         data_rd_i,
  input  logic         data_wr_i,
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] clr_mask_o,
  output logic         armed_o
);
  logic [W-1:0] snap_q;
  logic         armed_q;
  logic [W-1:0] wr_sel;

  assign wr_sel = WR_CLEAR_SET[W-1:0];

  always_comb begin
    clr_mask_o = '0;
    if (armed_q) begin
      if (data_wr_i) clr_mask_o = clr_mask_o | (snap_q & wr_sel);
      if (data_rd_i) clr_mask_o = clr_mask_o | (snap_q & ~wr_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      snap_q  <= '0;
    end else if (stat_rd_i) begin
      armed_q <= 1'b1;
      snap_q  <= flags_i;
    end else if (data_rd_i || data_wr_i) begin
      armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;

  p_latch_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_rd_i || data_wr_i) && !stat_rd_i) |=> !armed_o);
endmodule

// File: rtl/uart_flag_idle_gate.sv
module uart_flag_idle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_ev_i,
  input  logic rx_ev_i,
  output logic idle_set_o,
  output logic locked_o
);
  logic lock_q;

  assign idle_set_o = idle_ev_i && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          lock_q <= 1'b0;
    else if (idle_set_o) lock_q <= 1'b1;
    else if (rx_ev_i)    lock_q <= 1'b0;
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(src_i & en_i);
  end

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_tx_moved,
  input  logic                ev_frame_done,
  input  logic                ev_special_done,
  input  logic                ev_rx_moved,
  input  logic                ev_idle_seen,
  input  logic                err_overrun,
  input  logic                err_noise,
  input  logic                err_framing,
  input  logic                err_parity,
  input  logic                bus_stat_rd,
  input  logic                bus_data_rd,
  input  logic                bus_data_wr,
  input  logic [IRQ_SRCS-1:0] irq_en,
  output logic [FLAG_W-1:0]   status,
  output logic                tx_load_ok,
  output logic                irq
);
  localparam int unsigned IRQ_LSB = FLAG_W - IRQ_SRCS;

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flags;
  logic              idle_set;
  logic              idle_locked;
  logic              seq_armed;

  uart_flag_idle_gate idle_gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_ev_i  (ev_idle_seen),
    .rx_ev_i    (ev_rx_moved),
    .idle_set_o (idle_set),
    .locked_o   (idle_locked)
  );

  // preamble/break completion is deliberately not routed to any set input
  always_comb begin
    set_vec         = '0;
    set_vec[B_TXE]  = ev_tx_moved;
    set_vec[B_TC]   = ev_frame_done;
    set_vec[B_RXR]  = ev_rx_moved;
    set_vec[B_IDLE] = idle_set;
    set_vec[B_OVR]  = err_overrun;
    set_vec[B_NSE]  = err_noise;
    set_vec[B_FRM]  = err_framing;
    set_vec[B_PAR]  = err_parity;
  end

  uart_flag_clear_seq #(.W(FLAG_W)) clear_seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd_i  (bus_stat_rd),
    .data_rd_i  (bus_data_rd),
    .data_wr_i  (bus_data_wr),
    .flags_i    (flags),
    .clr_mask_o (clr_vec),
    .armed_o    (seq_armed)
  );

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    uart_flag_cell #(.RST_VAL(RESET_FLAGS[g])) cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (flags[g])
    );
  end

  uart_flag_irq #(.N(IRQ_SRCS)) irq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (flags[FLAG_W-1:IRQ_LSB]),
    .en_i  (irq_en),
    .irq_o (irq)
  );

  assign status     = flags;
  assign tx_load_ok = !flags[B_TXE];

  p_no_tc_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_special_done && !ev_frame_done && !status[B_TC]) |=> !status[B_TC]);

  p_txe_hold_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_armed && status[B_TXE]) |=> status[B_TXE]);

  p_idle_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_locked && !status[B_IDLE]) |=> !status[B_IDLE]);
endmodule

// File: tb/uart_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_flag_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_moved = 0, ev_frame_done = 0, ev_special_done = 0, ev_rx_moved = 0, ev_idle_seen = 0;
  logic err_overrun = 0, err_noise = 0, err_framing = 0, err_parity = 0;
  logic bus_stat_rd = 0, bus_data_rd = 0, bus_data_wr = 0;
  logic [3:0] irq_en = 4'h0;
  logic [7:0] status;
  logic tx_load_ok, irq;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_moved(ev_tx_moved), .ev_frame_done(ev_frame_done),
    .ev_special_done(ev_special_done), .ev_rx_moved(ev_rx_moved),
    .ev_idle_seen(ev_idle_seen), .err_overrun(err_overrun),
    .err_noise(err_noise), .err_framing(err_framing), .err_parity(err_parity),
    .bus_stat_rd(bus_stat_rd), .bus_data_rd(bus_data_rd), .bus_data_wr(bus_data_wr),
    .irq_en(irq_en), .status(status), .tx_load_ok(tx_load_ok), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock: inputs set before this call are captured at the rising edge,
  // then all pulses drop at the following falling edge, where outputs are sampled
  task automatic tick();
    @(negedge clk);
    ev_tx_moved = 0; ev_frame_done = 0; ev_special_done = 0; ev_rx_moved = 0;
    ev_idle_seen = 0; err_overrun = 0; err_noise = 0; err_framing = 0;
    err_parity = 0; bus_stat_rd = 0; bus_data_rd = 0; bus_data_wr = 0;
  endtask

  task automatic seq_read();
    bus_stat_rd = 1; tick();
    bus_data_rd = 1; tick();
  endtask

  task automatic seq_write();
    bus_stat_rd = 1; tick();
    bus_data_wr = 1; tick();
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'hC0);
    check("R1 tx_load_ok", {7'd0, tx_load_ok}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_tx_path();
    seq_write();
    check("R5 write sequence clears bits 7,6", status, 8'h00);
    check("R3 tx_load_ok when empty clear", {7'd0, tx_load_ok}, 8'h01);
    ev_tx_moved = 1; tick();
    check("R3 tx moved sets bit7", status, 8'h80);
    check("R3 tx_load_ok drops", {7'd0, tx_load_ok}, 8'h00);
    ev_frame_done = 1; tick();
    check("R4 frame done sets bit6", status, 8'hC0);
  endtask

  task automatic t_special_and_unarmed();
    seq_write();
    ev_special_done = 1; tick();
    check("R4 preamble/break ignored", status, 8'h00);
    ev_tx_moved = 1; tick();
    bus_data_wr = 1; tick();
    check("R5 unarmed write no effect", status, 8'h80);
    seq_read();
    check("R7 data read keeps bit7", status, 8'h80);
    seq_write();
    check("R5 clear again", status, 8'h00);
  endtask

  task automatic t_rx_snapshot();
    ev_rx_moved = 1; tick();
    check("R2 rx sets bit5", status, 8'h20);
    bus_stat_rd = 1; tick();
    err_overrun = 1; tick();
    check("R2 overrun sets bit3", status, 8'h28);
    bus_data_rd = 1; tick();
    check("R6 late flag survives", status, 8'h08);
    seq_write();
    check("R7 write keeps error bits", status, 8'h08);
    seq_read();
    check("R6 read sequence clears error", status, 8'h00);
  endtask

  task automatic t_errors();
    err_overrun = 1; err_noise = 1; err_framing = 1; err_parity = 1; tick();
    check("R2 error bits 3..0", status, 8'h0F);
    seq_read();
    check("R6 errors cleared", status, 8'h00);
  endtask

  task automatic t_consume();
    ev_rx_moved = 1; tick();
    seq_read();
    check("R6 rx cleared", status, 8'h00);
    ev_rx_moved = 1; tick();
    bus_data_rd = 1; tick();
    check("R7 latch used up", status, 8'h20);
    seq_read();
    check("R7 re-armed clear", status, 8'h00);
  endtask

  task automatic t_set_wins();
    ev_rx_moved = 1; tick();
    bus_stat_rd = 1; tick();
    bus_data_rd = 1; ev_rx_moved = 1; tick();
    check("R8 set beats clear", status, 8'h20);
    seq_read();
    check("R8 cleanup", status, 8'h00);
  endtask

  task automatic t_idle_lock();
    ev_idle_seen = 1; tick();
    check("R9 idle sets bit4", status, 8'h10);
    seq_read();
    check("R9 idle cleared", status, 8'h00);
    ev_idle_seen = 1; tick();
    check("R9 idle locked out", status, 8'h00);
    ev_rx_moved = 1; tick();
    ev_idle_seen = 1; tick();
    check("R9 idle after rx", status, 8'h30);
    seq_read();
  endtask

  task automatic t_irq();
    irq_en = 4'h0;
    ev_rx_moved = 1; tick();
    tick();
    check("R10 disabled", {7'd0, irq}, 8'h00);
    irq_en = 4'b0010; tick();
    check("R10 rx enabled", {7'd0, irq}, 8'h01);
    seq_read();
    tick();
    check("R10 falls after clear", {7'd0, irq}, 8'h00);
    irq_en = 4'hF;
    err_parity = 1; tick();
    tick();
    check("R10 errors never interrupt", {7'd0, irq}, 8'h00);
    seq_read();
    ev_tx_moved = 1; tick();
    check("R10 registered lag", {7'd0, irq}, 8'h00);
    tick();
    check("R10 tx empty interrupt", {7'd0, irq}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx_path();
    t_special_and_unarmed();
    t_rx_snapshot();
    t_errors();
    t_consume();
    t_set_wins();
    t_idle_lock();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule